// File: doc/BRIEF.md
# Serial Display Link Pixel Deframer

This block sits behind the line receivers of a low-swing serial display link and turns the recovered bit streams back into parallel pixels. Each data lane delivers one bit per cycle in which `bit_en` is high. A word-start strobe, aligned to the pixel clock, marks the first bit of every word, so the words need no framing bits of their own. Each word is fifteen bits long. The colour bits of a pixel are split across two lanes. In single-lane mode they are sent as two words in a row on lane 0.

Every word has its own odd-parity bit. When a pixel passes the check, it is loaded into a registered output bus and `pix_valid` pulses for one cycle. A pixel fails if either of its words fails parity, or if a word is cut short by an early word-start strobe. A failed pixel still produces a `pix_valid` pulse, but the bus repeats the last good pixel. A saturating counter, readable and clearable on a sideband port, counts the failures.

A four-state machine controls the receive sequence:
- ST_IDLE waits for a word start, then moves to ST_SHIFT_A.
- ST_SHIFT_A collects the first word. An early word start restarts ST_SHIFT_A. When the word is complete, the machine returns to ST_IDLE in two-lane mode, or moves to ST_WAIT_B in single-lane mode.
- ST_WAIT_B waits for a word start and then moves to ST_SHIFT_B. In two-lane mode a word start here moves to ST_SHIFT_A instead.
- ST_SHIFT_B collects the second word. It returns to ST_IDLE when the word is complete, or moves to ST_SHIFT_A on an early word start.

Top module: `sdl_pixel_deframer`

## Requirements
- R1: A word is 15 bits. It begins at the first cycle in which `bit_en` and `word_start` are both high; that cycle's bit is the word's first bit. Any further `bit_en` cycles after the fifteenth bit, without a new word start, are ignored: no valid pulse, no output change, no error.
- R2: In two-lane mode, the lane 0 word, first bit first, is R[7:0], G[7:4], VS, HS, P. The lane 1 word is G[3:0], B[7:0], X, X, P. The output bus `pix_rgb` is {R,G,B}. `pix_valid` is high in the cycle after the clock edge that samples the fifteenth bit.
- R3: A word passes only if its 15 bits hold an odd number of ones. A pixel whose words all pass is loaded into `pix_rgb`, `pix_vs` and `pix_hs`, and leaves the error count unchanged.
- R4: If a word of a pixel fails parity, `pix_valid` still pulses once. The outputs keep the last good pixel, and the error count rises by one for that pixel, even if both of its words fail.
- R5: The two X bits in the lane 1 word are ignored, apart from their part in the parity check.
- R6: With `two_lane` low, a pixel is two consecutive words on lane 0: the lane 0 layout, then the lane 1 layout. `pix_valid` pulses only after the second word, and the `lane1_bit` input is ignored.
- R7: A word start that arrives before a word has its 15 bits is a failure. It pulses `pix_valid` with the held pixel and adds one to the error count. The bit that arrives with that strobe begins a new first word.
- R8: After reset, `pix_rgb`, `pix_vs`, `pix_hs`, `pix_valid` and `err_count` are all zero. A failure before any good pixel therefore outputs black with both sync bits low.
- R9: `err_count` saturates at 255.
- R10: `err_clr` sets `err_count` to zero on the next edge, and takes priority over a failure in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| two_lane | input | 1 | 1: two-lane mode, 0: single-lane mode on lane 0 |
| bit_en | input | 1 | Qualifies the lane bits and the word-start strobe |
| word_start | input | 1 | The current bit is the first bit of a word |
| lane0_bit | input | 1 | Serial data, lane 0 |
| lane1_bit | input | 1 | Serial data, lane 1 |
| err_clr | input | 1 | Clears the error counter |
| pix_rgb | output | 24 | Pixel colour {R,G,B} |
| pix_vs | output | 1 | Vertical sync of the pixel |
| pix_hs | output | 1 | Horizontal sync of the pixel |
| pix_valid | output | 1 | One-cycle pulse for each pixel slot |
| err_count | output | 8 | Saturating failure count |

## Verification
Some behaviour is checked by the assertions on every cycle:
- After any failure, a valid pulse goes out and the output pixel does not change.
- The bit counter never passes the last bit of a word.
- The first word in single-lane mode never raises `pix_valid`.
- The error counter clears, saturates, and moves only when there is a failure.

Other behaviour only the bench's scenarios can show. These are the bit order and field positions of the decoded pixel, the indifference to the reserved bits, the treatment of surplus bits, the restart after a truncated word, the black output before the first good pixel, and single-lane assembly while lane 1 carries noise.

// File: rtl/sdl_pkg.sv
package sdl_pkg;
    localparam int COLOR_W = 8;
    localparam int WORD_W  = COLOR_W + COLOR_W / 2 + 3;
    localparam int PIX_W   = 3 * COLOR_W;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT_A,
        ST_WAIT_B,
        ST_SHIFT_B
    } rx_state_e;

    typedef struct packed {
        logic [PIX_W-1:0] rgb;
        logic             vs;
        logic             hs;
    } pixel_t;
endpackage

// File: rtl/sdl_lane_shift.sv
module sdl_lane_shift #(
    parameter int W = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic         din,
    input  logic         use_stored,
    output logic [W-1:0] word
);
    logic [W-1:0] word_q;
    logic [W-1:0] word_nx;

    assign word_nx = load ? {{(W-1){1'b0}}, din} : {word_q[W-2:0], din};
    assign word    = use_stored ? word_q : word_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (load || shift) begin
            word_q <= word_nx;
        end
    end
endmodule

// File: rtl/sdl_word_check.sv
module sdl_word_check
    import sdl_pkg::*;
(
    input  logic [WORD_W-1:0] w_first,
    input  logic [WORD_W-1:0] w_second,
    output pixel_t            pix,
    output logic              ok
);
    localparam int HALF = COLOR_W / 2;

    always_comb begin
        pix.rgb = {w_first[WORD_W-1 -: COLOR_W],
                   w_first[WORD_W-1-COLOR_W -: HALF],
                   w_second[WORD_W-1 -: HALF],
                   w_second[WORD_W-1-HALF -: COLOR_W]};
        pix.vs  = w_first[2];
        pix.hs  = w_first[1];
        ok      = (^w_first) & (^w_second);
    end
endmodule

// File: rtl/sdl_err_counter.sv
module sdl_err_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] MAX = {W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc && count != MAX) begin
            count <= count + 1'b1;
        end
    end

    AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> count == '0); // R10
    AST_ERR_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (count == MAX && !clr) |=> count == MAX); // R9
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !inc) |=> $stable(count)); // R3
endmodule

// File: rtl/sdl_pixel_deframer.sv
module sdl_pixel_deframer
    import sdl_pkg::*;
#(
    parameter int ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             two_lane,
    input  logic             bit_en,
    input  logic             word_start,
    input  logic             lane0_bit,
    input  logic             lane1_bit,
    input  logic             err_clr,
    output logic [PIX_W-1:0] pix_rgb,
    output logic             pix_vs,
    output logic             pix_hs,
    output logic             pix_valid,
    output logic [ERR_W-1:0] err_count
);
    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    rx_state_e state_q, state_nx;
    logic [CNT_W-1:0] cnt_q;
    logic [WORD_W-1:0] w0, w1;
    pixel_t dec_pix, out_q;
    logic dec_ok, bad_q;

    logic ws, start_a, start_b, in_shift, step, last_bit, trunc, pix_done, err_inc;

    assign ws       = bit_en & word_start;
    assign start_b  = ws & (state_q == ST_WAIT_B) & ~two_lane;
    assign start_a  = ws & ~start_b;
    assign in_shift = (state_q == ST_SHIFT_A) || (state_q == ST_SHIFT_B);
    assign trunc    = ws & in_shift;
    assign step     = bit_en & ~word_start & in_shift;
    assign last_bit = step & (cnt_q == LAST);
    assign pix_done = last_bit & (state_q == ST_SHIFT_B || two_lane);
    assign err_inc  = (pix_done & ~dec_ok) | trunc;

    sdl_lane_shift #(.W(WORD_W)) u_sr0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (start_a),
        .shift      (step & (state_q == ST_SHIFT_A)),
        .din        (lane0_bit),
        .use_stored (state_q == ST_SHIFT_B),
        .word       (w0)
    );

    sdl_lane_shift #(.W(WORD_W)) u_sr1 (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (two_lane ? start_a : start_b),
        .shift      (step & (state_q == (two_lane ? ST_SHIFT_A : ST_SHIFT_B))),
        .din        (two_lane ? lane1_bit : lane0_bit),
        .use_stored (1'b0),
        .word       (w1)
    );

    sdl_word_check u_check (
        .w_first  (w0),
        .w_second (w1),
        .pix      (dec_pix),
        .ok       (dec_ok)
    );

    sdl_err_counter #(.W(ERR_W)) u_errs (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (err_inc),
        .clr   (err_clr),
        .count (err_count)
    );

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_a) state_nx = ST_SHIFT_A;
            ST_SHIFT_A: if (start_a) state_nx = ST_SHIFT_A;
                        else if (last_bit) state_nx = two_lane ? ST_IDLE : ST_WAIT_B;
            ST_WAIT_B:  if (start_b) state_nx = ST_SHIFT_B;
                        else if (start_a) state_nx = ST_SHIFT_A;
            ST_SHIFT_B: if (start_a) state_nx = ST_SHIFT_A;
                        else if (last_bit) state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_nx;
            if (ws)            cnt_q <= CNT_W'(1);
            else if (last_bit) cnt_q <= '0;
            else if (step)     cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q     <= '0;
            pix_valid <= 1'b0;
            bad_q     <= 1'b0;
        end else begin
            pix_valid <= pix_done | trunc;
            bad_q     <= err_inc;
            if (pix_done && dec_ok) out_q <= dec_pix;
        end
    end

    assign pix_rgb = out_q.rgb;
    assign pix_vs  = out_q.vs;
    assign pix_hs  = out_q.hs;

    AST_HOLD_ON_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        bad_q |-> $stable({pix_rgb, pix_vs, pix_hs})); // R4
    AST_FAIL_PULSES: assert property (@(posedge clk) disable iff (!rst_n)
        bad_q |-> pix_valid); // R7
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST); // R1
    AST_FIRST_HALF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_SHIFT_A && state_q == ST_WAIT_B) |-> !pix_valid); // R6
endmodule

// File: tb/sdl_pixel_deframer_test.sv
module sdl_pixel_deframer_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic two_lane = 1'b1;
    logic bit_en = 1'b0;
    logic word_start = 1'b0;
    logic lane0_bit = 1'b0;
    logic lane1_bit = 1'b0;
    logic err_clr = 1'b0;
    logic [23:0] pix_rgb;
    logic pix_vs, pix_hs, pix_valid;
    logic [7:0] err_count;

    int checks = 0;
    int errors = 0;
    int vcount = 0;
    logic [25:0] cap [0:15];

    always #10 clk = ~clk;

    sdl_pixel_deframer uut (
        .clk(clk), .rst_n(rst_n), .two_lane(two_lane), .bit_en(bit_en),
        .word_start(word_start), .lane0_bit(lane0_bit), .lane1_bit(lane1_bit),
        .err_clr(err_clr), .pix_rgb(pix_rgb), .pix_vs(pix_vs), .pix_hs(pix_hs),
        .pix_valid(pix_valid), .err_count(err_count)
    );

    always @(posedge clk) begin
        #5;
        if (pix_valid === 1'b1) begin
            cap[vcount % 16] = {pix_rgb, pix_vs, pix_hs};
            vcount++;
        end
    end

    function automatic logic [14:0] mk0(logic [7:0] r, logic [7:0] g, logic vs, logic hs, logic bad);
        logic [13:0] d = {r, g[7:4], vs, hs};
        return {d, (~^d) ^ bad};
    endfunction

    function automatic logic [14:0] mk1(logic [7:0] g, logic [7:0] b, logic [1:0] res, logic bad);
        logic [13:0] d = {g[3:0], b, res};
        return {d, (~^d) ^ bad};
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    task automatic drive_word(logic [14:0] a, logic [14:0] b, int nbits);
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            bit_en = 1'b1;
            word_start = (i == 0);
            lane0_bit = a[14 - i];
            lane1_bit = b[14 - i];
        end
        @(negedge clk);
        bit_en = 1'b0;
        word_start = 1'b0;
    endtask

    task automatic send2(logic [7:0] r, logic [7:0] g, logic [7:0] b, logic vs, logic hs,
                         logic [1:0] res, logic bad0, logic bad1);
        drive_word(mk0(r, g, vs, hs, bad0), mk1(g, b, res, bad1), 15);
        settle();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
    endtask

    task automatic t_reset();
        chk("R8", "rgb after reset", 32'(pix_rgb), 32'h0);
        chk("R8", "sync after reset", {30'h0, pix_vs, pix_hs}, 32'h0);
        chk("R8", "valid after reset", 32'(pix_valid), 32'h0);
        chk("R8", "count after reset", 32'(err_count), 32'h0);
    endtask

    task automatic t_bad_first();
        int v0 = vcount;
        send2(8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b1, 2'b00, 1'b1, 1'b0);
        chk("R8", "pulse on early failure", 32'(vcount - v0), 32'd1);
        chk("R8", "black before first good", 32'(cap[v0 % 16]), 32'h0);
        chk("R4", "count after failure", 32'(err_count), 32'd1);
    endtask

    task automatic t_good();
        int v0 = vcount;
        send2(8'hA5, 8'h3C, 8'hF0, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0);
        chk("R2", "one valid pulse", 32'(vcount - v0), 32'd1);
        chk("R2", "decoded pixel", 32'(cap[v0 % 16]), 32'({24'hA53CF0, 2'b10}));
        chk("R3", "good keeps count", 32'(err_count), 32'd1);
        chk("R2", "valid is a pulse", 32'(pix_valid), 32'h0);
    endtask

    task automatic t_reserved();
        int v0 = vcount;
        send2(8'h12, 8'hE7, 8'h81, 1'b0, 1'b1, 2'b11, 1'b0, 1'b0);
        chk("R5", "reserved bits set", 32'(cap[v0 % 16]), 32'({24'h12E781, 2'b01}));
        send2(8'h12, 8'hE7, 8'h81, 1'b0, 1'b1, 2'b01, 1'b0, 1'b0);
        chk("R5", "reserved bits mixed", 32'(cap[(v0 + 1) % 16]), 32'({24'h12E781, 2'b01}));
        chk("R5", "no error from reserved", 32'(err_count), 32'd1);
    endtask

    task automatic t_bad_lanes();
        int v0 = vcount;
        send2(8'h00, 8'h11, 8'h22, 1'b1, 1'b0, 2'b00, 1'b0, 1'b1);
        chk("R4", "lane1 fail holds", 32'(cap[v0 % 16]), 32'({24'h12E781, 2'b01}));
        send2(8'h33, 8'h44, 8'h55, 1'b1, 1'b1, 2'b00, 1'b1, 1'b1);
        chk("R4", "double fail holds", 32'(cap[(v0 + 1) % 16]), 32'({24'h12E781, 2'b01}));
        chk("R4", "count one per pixel", 32'(err_count), 32'd3);
    endtask

    task automatic t_overrun();
        int v0 = vcount;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            bit_en = 1'b1;
            lane0_bit = i[0];
            lane1_bit = ~i[0];
        end
        @(negedge clk);
        bit_en = 1'b0;
        settle();
        chk("R1", "surplus bits no pulse", 32'(vcount - v0), 32'd0);
        chk("R1", "surplus bits no error", 32'(err_count), 32'd3);
        chk("R1", "surplus bits hold pixel", 32'(pix_rgb), 32'h12E781);
    endtask

    task automatic t_trunc();
        int v0 = vcount;
        drive_word(15'h5555, 15'h2AAA, 7);
        drive_word(mk0(8'hC3, 8'h96, 1'b0, 1'b0, 1'b0), mk1(8'h96, 8'h69, 2'b00, 1'b0), 15);
        settle();
        chk("R7", "two pulses", 32'(vcount - v0), 32'd2);
        chk("R7", "truncation holds", 32'(cap[v0 % 16]), 32'({24'h12E781, 2'b01}));
        chk("R7", "restart word decoded", 32'(cap[(v0 + 1) % 16]), 32'({24'hC39669, 2'b00}));
        chk("R7", "truncation counted", 32'(err_count), 32'd4);
    endtask

    task automatic t_one_lane();
        int v0 = vcount;
        two_lane = 1'b0;
        drive_word(mk0(8'h7E, 8'hB4, 1'b1, 1'b1, 1'b0), 15'h7FFF, 15);
        settle();
        chk("R6", "no pulse after first word", 32'(vcount - v0), 32'd0);
        drive_word(mk1(8'hB4, 8'h0F, 2'b00, 1'b0), 15'h1234, 15);
        settle();
        chk("R6", "pulse after second word", 32'(vcount - v0), 32'd1);
        chk("R6", "single-lane pixel", 32'(cap[v0 % 16]), 32'({24'h7EB40F, 2'b11}));
        drive_word(mk0(8'h01, 8'h02, 1'b0, 1'b0, 1'b0), 15'h0, 15);
        drive_word(mk1(8'h02, 8'h03, 2'b00, 1'b1), 15'h7FFF, 15);
        settle();
        chk("R6", "single-lane fail holds", 32'(cap[(v0 + 1) % 16]), 32'({24'h7EB40F, 2'b11}));
        chk("R6", "single-lane fail counted", 32'(err_count), 32'd5);
        two_lane = 1'b1;
    endtask

    task automatic t_saturate();
        for (int i = 0; i < 255; i++)
            drive_word(15'h0000, 15'h0000, 15);
        settle();
        chk("R9", "count saturates", 32'(err_count), 32'd255);
    endtask

    task automatic t_clear();
        @(negedge clk);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        #1;
        chk("R10", "clear to zero", 32'(err_count), 32'd0);
        send2(8'h0, 8'h0, 8'h0, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0);
        chk("R10", "count after clear", 32'(err_count), 32'd1);
        err_clr = 1'b1;
        drive_word(15'h0000, 15'h0000, 15);
        err_clr = 1'b0;
        settle();
        chk("R10", "clear beats failure", 32'(err_count), 32'd0);
    endtask

    initial begin
        do_reset();
        t_reset();
        t_bad_first();
        t_good();
        t_reserved();
        t_bad_lanes();
        t_overrun();
        t_trunc();
        t_one_lane();
        t_saturate();
        t_clear();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule